// File: doc/BRIEF.md
# General-Purpose Event and System Control Interrupt Combiner

This block keeps a small general-purpose event register block and a processor-presence bitmap, and from them and the power-management event vectors it forms one level-sensitive system control interrupt. Software reaches both register spaces through a byte-wide bus. Events from a hot-plug controller set status bits. Software acknowledges an event by writing ones to its status bits and masks each event with its own enable bit.

The event register block is four bytes long. Offsets 0 and 1 hold the status halves and offsets 2 and 3 hold the enable halves. A wider software access is assumed to arrive as a sequence of byte accesses. The presence bitmap holds one bit per processor ID. A plug event for an ID sets its bit and an unplug event clears it. Either action also raises the processor-hotplug status bit. The block also produces the condition under which the external timer should arm its overflow wakeup.

All outputs follow the registered state and the power-management inputs combinationally. A register write or a hot-plug event is therefore visible on the interrupt output in the cycle after the clock edge that stores it.

Top module: `gpe_sci_hub`

## Requirements
- R1: While and after reset, all four event register bytes read 0, the presence bitmap equals the BOOT_MASK parameter (default: processors 0 and 2 present, so bitmap byte 0 reads 0x05 and every other byte reads 0x00), and `sci` is low when the power-management inputs are zero.
- R2: Status bytes sit at event offsets 0 and 1. Writing a byte there clears each status bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R3: Enable bytes sit at event offsets 2 and 3. They are plain read/write and read back the last value written.
- R4: `sci` is high whenever `pm1_sts & pm1_en` has any of bit 0 (timer), bit 5 (global lock), bit 8 (power button) or bit 10 (real-time clock) set. Other bits of that product have no effect on `sci`.
- R5: `sci` is also high whenever status byte 0 AND enable byte 0 has bit 1 (slot hotplug) or bit 2 (processor hotplug) set. No other event bit, and nothing in byte 1, drives `sci`.
- R6: A `cpu_plug` strobe sets bit (`cpu_id` mod 8) of bitmap byte (`cpu_id` div 8), and a `cpu_unplug` strobe clears that bit. Either strobe sets status byte 0 bit 2.
- R7: With `reg_sel_map` high, a read returns bitmap byte `reg_addr`. Writes to the bitmap are ignored and change neither the bitmap nor the event registers.
- R8: `tmr_arm` is high exactly when `pm1_en` bit 0 is set and `pm1_sts` bit 0 is clear.
- R9: A `slot_evt` strobe sets status byte 0 bit 1.
- R10: When an event sets a status bit in the same cycle as a write-one-to-clear of that bit, the bit ends up set.
- R11: When `cpu_plug` and `cpu_unplug` arrive in the same cycle, the plug wins and the bitmap bit ends up set.
- R12: With `reg_sel_map` low, offsets 4 to 31 read as 0x00, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_sel_map | input | 1 | 1 selects the presence bitmap, 0 selects the event register block |
| reg_addr | input | 5 | Byte offset within the selected space |
| reg_we | input | 1 | Write strobe for one byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed byte, combinational |
| pm1_sts | input | 16 | Power-management event status vector |
| pm1_en | input | 16 | Power-management event enable vector |
| slot_evt | input | 1 | Slot hotplug event strobe |
| cpu_plug | input | 1 | Processor plug strobe |
| cpu_unplug | input | 1 | Processor unplug strobe |
| cpu_id | input | 8 | Processor ID carried with the plug or unplug strobe |
| sci | output | 1 | Level-sensitive system control interrupt |
| tmr_arm | output | 1 | Request to arm the timer overflow wakeup |

## Verification
The bench targets the write-one-to-clear semantics with mixed one and zero data. A design that cleared on any write, or that stored the written byte, would lose or invent pending events. It drives each power-management bit on its own, including bits outside the interrupt subset and bits that are pending but not enabled, so that a widened or narrowed mask shows up as a wrong `sci` level. It also checks the same-cycle collisions: event against clear, and plug against unplug. Getting the priority wrong drops a hot-plug notification or leaves a stale presence bit. Finally, it writes to the read-only bitmap and to unmapped event offsets and reads back, so that a leaking decode would show up as a changed byte.

// File: rtl/gpe_sci_pkg.sv
package gpe_sci_pkg;

    localparam int PM1_W       = 16;
    localparam int BYTE_W      = 8;
    localparam int GPE_HALF_N  = 2;
    localparam int CPU_ID_W    = 8;
    localparam int MAP_BYTES_D = (1 << CPU_ID_W) / BYTE_W;

    // bits of the PM1 product that may raise the interrupt
    localparam int PM1_TMR_BIT  = 0;
    localparam int PM1_GLK_BIT  = 5;
    localparam int PM1_PWRB_BIT = 8;
    localparam int PM1_RTC_BIT  = 10;
    localparam logic [PM1_W-1:0] PM1_SCI_MASK =
        (PM1_W'(1) << PM1_TMR_BIT)  | (PM1_W'(1) << PM1_GLK_BIT) |
        (PM1_W'(1) << PM1_PWRB_BIT) | (PM1_W'(1) << PM1_RTC_BIT);

    // event byte 0 bits that may raise the interrupt
    localparam int GPE_SLOT_BIT = 1;
    localparam int GPE_CPU_BIT  = 2;
    localparam logic [BYTE_W-1:0] GPE0_SCI_MASK =
        (BYTE_W'(1) << GPE_SLOT_BIT) | (BYTE_W'(1) << GPE_CPU_BIT);

    typedef enum logic [1:0] {
        OFS_STS_LO = 2'd0,
        OFS_STS_HI = 2'd1,
        OFS_EN_LO  = 2'd2,
        OFS_EN_HI  = 2'd3
    } gpe_ofs_e;

    typedef struct packed {
        logic              we;
        gpe_ofs_e          ofs;
        logic [BYTE_W-1:0] data;
    } gpe_wr_t;

    typedef struct packed {
        logic                plug;
        logic                unplug;
        logic [CPU_ID_W-1:0] id;
    } cpu_evt_t;

    // clear on written ones, then apply new events (events win)
    function automatic logic [BYTE_W-1:0] w1c_update(
        input logic [BYTE_W-1:0] cur,
        input logic              clr_en,
        input logic [BYTE_W-1:0] clr,
        input logic [BYTE_W-1:0] set
    );
        logic [BYTE_W-1:0] kept;
        kept = clr_en ? (cur & ~clr) : cur;
        return kept | set;
    endfunction

endpackage

// File: rtl/gpe_regfile.sv
module gpe_regfile
    import gpe_sci_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst,
    input  gpe_wr_t                             wr,
    input  logic [BYTE_W-1:0]                   set_lo,
    output logic [GPE_HALF_N-1:0][BYTE_W-1:0]   sts,
    output logic [GPE_HALF_N-1:0][BYTE_W-1:0]   en
);

    logic [GPE_HALF_N-1:0][BYTE_W-1:0] sts_q;
    logic [GPE_HALF_N-1:0][BYTE_W-1:0] en_q;

    for (genvar h = 0; h < GPE_HALF_N; h++) begin : g_half
        localparam gpe_ofs_e STS_OFS = gpe_ofs_e'(h);
        localparam gpe_ofs_e EN_OFS  = gpe_ofs_e'(h + GPE_HALF_N);
        logic [BYTE_W-1:0] set_bits;

        if (h == 0) begin : g_evt
            assign set_bits = set_lo;
        end else begin : g_noevt
            assign set_bits = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q[h] <= '0;
                en_q[h]  <= '0;
            end else begin
                sts_q[h] <= w1c_update(sts_q[h], wr.we && (wr.ofs == STS_OFS),
                                       wr.data, set_bits);
                if (wr.we && (wr.ofs == EN_OFS)) begin
                    en_q[h] <= wr.data;
                end
            end
        end
    end

    assign sts = sts_q;
    assign en  = en_q;

endmodule

// File: rtl/cpu_presence_map.sv
module cpu_presence_map
    import gpe_sci_pkg::*;
#(
    parameter int                       MAP_BYTES = MAP_BYTES_D,
    parameter logic [MAP_BYTES*8-1:0]   BOOT_MASK = 'h5,
    localparam int                      IDX_W     = $clog2(MAP_BYTES)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  cpu_evt_t                    evt,
    input  logic [IDX_W-1:0]            rd_idx,
    output logic [BYTE_W-1:0]           rd_byte,
    output logic [MAP_BYTES*8-1:0]      bits
);

    localparam int BIT_SEL_W = $clog2(BYTE_W);

    logic [MAP_BYTES-1:0][BYTE_W-1:0] map_q;
    logic [BYTE_W-1:0]                bit_onehot;
    logic [IDX_W-1:0]                 evt_byte;

    assign bit_onehot = BYTE_W'(1) << evt.id[BIT_SEL_W-1:0];
    assign evt_byte   = evt.id[BIT_SEL_W +: IDX_W];

    for (genvar b = 0; b < MAP_BYTES; b++) begin : g_byte
        logic hit;
        assign hit = (evt_byte == IDX_W'(b));

        always_ff @(posedge clk) begin
            if (rst) begin
                map_q[b] <= BOOT_MASK[b*BYTE_W +: BYTE_W];
            end else if (hit && evt.plug) begin
                map_q[b] <= map_q[b] | bit_onehot;
            end else if (hit && evt.unplug) begin
                map_q[b] <= map_q[b] & ~bit_onehot;
            end
        end
    end

    assign rd_byte = map_q[rd_idx];
    assign bits    = map_q;

endmodule

// File: rtl/sci_combine.sv
module sci_combine
    import gpe_sci_pkg::*;
(
    input  logic [PM1_W-1:0]  pm1_sts,
    input  logic [PM1_W-1:0]  pm1_en,
    input  logic [BYTE_W-1:0] gpe_sts_lo,
    input  logic [BYTE_W-1:0] gpe_en_lo,
    output logic              sci,
    output logic              tmr_arm
);

    logic pm1_hit;
    logic gpe_hit;

    always_comb begin
        pm1_hit = |(pm1_sts & pm1_en & PM1_SCI_MASK);
        gpe_hit = |(gpe_sts_lo & gpe_en_lo & GPE0_SCI_MASK);
        sci     = pm1_hit | gpe_hit;
        tmr_arm = pm1_en[PM1_TMR_BIT] & ~pm1_sts[PM1_TMR_BIT];
    end

endmodule

// File: rtl/gpe_sci_hub.sv
module gpe_sci_hub
    import gpe_sci_pkg::*;
#(
    parameter int                       MAP_BYTES = MAP_BYTES_D,
    parameter logic [MAP_BYTES*8-1:0]   BOOT_MASK = 'h5,
    localparam int                      ADDR_W    = $clog2(MAP_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_sel_map,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_we,
    input  logic [BYTE_W-1:0]    reg_wdata,
    output logic [BYTE_W-1:0]    reg_rdata,
    input  logic [PM1_W-1:0]     pm1_sts,
    input  logic [PM1_W-1:0]     pm1_en,
    input  logic                 slot_evt,
    input  logic                 cpu_plug,
    input  logic                 cpu_unplug,
    input  logic [CPU_ID_W-1:0]  cpu_id,
    output logic                 sci,
    output logic                 tmr_arm
);

    localparam int GPE_OFS_W = $clog2(2 * GPE_HALF_N);

    logic                              gpe_in_range;
    gpe_wr_t                           gpe_wr;
    cpu_evt_t                          cpu_evt;
    logic [BYTE_W-1:0]                 set_lo;
    logic [GPE_HALF_N-1:0][BYTE_W-1:0] gpe_sts;
    logic [GPE_HALF_N-1:0][BYTE_W-1:0] gpe_en;
    logic [BYTE_W-1:0]                 map_rd;
    logic [BYTE_W-1:0]                 gpe_rd;
    logic [MAP_BYTES*8-1:0]            map_bits;
    logic [BYTE_W-1:0]                 gpe_sts0;
    logic [BYTE_W-1:0]                 gpe_en0;

    // event block decode: only the low offsets are mapped
    assign gpe_in_range = ~reg_sel_map &&
                          (reg_addr[ADDR_W-1:GPE_OFS_W] == '0);

    always_comb begin
        gpe_wr.we   = reg_we && gpe_in_range;
        gpe_wr.ofs  = gpe_ofs_e'(reg_addr[GPE_OFS_W-1:0]);
        gpe_wr.data = reg_wdata;

        cpu_evt.plug   = cpu_plug;
        cpu_evt.unplug = cpu_unplug;
        cpu_evt.id     = cpu_id;

        set_lo = '0;
        set_lo[GPE_SLOT_BIT] = slot_evt;
        set_lo[GPE_CPU_BIT]  = cpu_plug | cpu_unplug;
    end

    gpe_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (gpe_wr),
        .set_lo (set_lo),
        .sts    (gpe_sts),
        .en     (gpe_en)
    );

    cpu_presence_map #(
        .MAP_BYTES (MAP_BYTES),
        .BOOT_MASK (BOOT_MASK)
    ) u_map (
        .clk     (clk),
        .rst     (rst),
        .evt     (cpu_evt),
        .rd_idx  (reg_addr),
        .rd_byte (map_rd),
        .bits    (map_bits)
    );

    assign gpe_sts0 = gpe_sts[0];
    assign gpe_en0  = gpe_en[0];

    sci_combine u_sci (
        .pm1_sts    (pm1_sts),
        .pm1_en     (pm1_en),
        .gpe_sts_lo (gpe_sts0),
        .gpe_en_lo  (gpe_en0),
        .sci        (sci),
        .tmr_arm    (tmr_arm)
    );

    always_comb begin
        unique case (gpe_wr.ofs)
            OFS_STS_LO: gpe_rd = gpe_sts[0];
            OFS_STS_HI: gpe_rd = gpe_sts[1];
            OFS_EN_LO:  gpe_rd = gpe_en[0];
            OFS_EN_HI:  gpe_rd = gpe_en[1];
            default:    gpe_rd = '0;
        endcase
        if (reg_sel_map) begin
            reg_rdata = map_rd;
        end else if (gpe_in_range) begin
            reg_rdata = gpe_rd;
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: rtl/gpe_sci_hub_chk.sv
module gpe_sci_hub_chk
    import gpe_sci_pkg::*;
#(
    parameter int MAP_BITS = 256,
    parameter int ADDR_W   = 5
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PM1_W-1:0]     pm1_sts,
    input logic [PM1_W-1:0]     pm1_en,
    input logic                 sci,
    input logic                 tmr_arm,
    input logic                 slot_evt,
    input logic                 cpu_plug,
    input logic                 cpu_unplug,
    input logic                 reg_we,
    input logic                 reg_sel_map,
    input logic [ADDR_W-1:0]    reg_addr,
    input logic [BYTE_W-1:0]    reg_wdata,
    input logic [BYTE_W-1:0]    sts0,
    input logic [BYTE_W-1:0]    en0,
    input logic [MAP_BITS-1:0]  map_bits
);

    // R4
    pm1_sci_chk: assert property (@(posedge clk) disable iff (rst)
        ((pm1_sts & pm1_en & PM1_SCI_MASK) != '0) |-> sci);

    // R5
    gpe_sci_chk: assert property (@(posedge clk) disable iff (rst)
        ((sts0 & en0 & GPE0_SCI_MASK) != '0) |-> sci);

    // R5
    sci_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (((pm1_sts & pm1_en & PM1_SCI_MASK) == '0) &&
         ((sts0 & en0 & GPE0_SCI_MASK) == '0)) |-> !sci);

    // R6
    cpu_evt_sts_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_plug || cpu_unplug) |=> sts0[GPE_CPU_BIT]);

    // R9
    slot_evt_sts_chk: assert property (@(posedge clk) disable iff (rst)
        slot_evt |=> sts0[GPE_SLOT_BIT]);

    // R7
    map_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_plug && !cpu_unplug) |=> $stable(map_bits));

    // R8
    tmr_block_chk: assert property (@(posedge clk) disable iff (rst)
        pm1_sts[PM1_TMR_BIT] |-> !tmr_arm);

    // R8
    tmr_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (pm1_en[PM1_TMR_BIT] && !pm1_sts[PM1_TMR_BIT]) |-> tmr_arm);

    // R2
    w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_sel_map && reg_addr == '0 &&
         !slot_evt && !cpu_plug && !cpu_unplug)
        |=> ((sts0 & $past(reg_wdata)) == '0));

endmodule

bind gpe_sci_hub gpe_sci_hub_chk #(
    .MAP_BITS (MAP_BYTES * 8),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pm1_sts     (pm1_sts),
    .pm1_en      (pm1_en),
    .sci         (sci),
    .tmr_arm     (tmr_arm),
    .slot_evt    (slot_evt),
    .cpu_plug    (cpu_plug),
    .cpu_unplug  (cpu_unplug),
    .reg_we      (reg_we),
    .reg_sel_map (reg_sel_map),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .sts0        (gpe_sts0),
    .en0         (gpe_en0),
    .map_bits    (map_bits)
);

// File: tb/sim_gpe_sci_hub.sv
`timescale 1ns/1ps
module sim_gpe_sci_hub;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_sel_map;
    logic [4:0]  reg_addr;
    logic        reg_we;
    logic [7:0]  reg_wdata;
    logic [7:0]  reg_rdata;
    logic [15:0] pm1_sts;
    logic [15:0] pm1_en;
    logic        slot_evt;
    logic        cpu_plug;
    logic        cpu_unplug;
    logic [7:0]  cpu_id;
    logic        sci;
    logic        tmr_arm;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    gpe_sci_hub u0 (
        .clk         (clk),
        .rst         (rst),
        .reg_sel_map (reg_sel_map),
        .reg_addr    (reg_addr),
        .reg_we      (reg_we),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .pm1_sts     (pm1_sts),
        .pm1_en      (pm1_en),
        .slot_evt    (slot_evt),
        .cpu_plug    (cpu_plug),
        .cpu_unplug  (cpu_unplug),
        .cpu_id      (cpu_id),
        .sci         (sci),
        .tmr_arm     (tmr_arm)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_sel_map = sel; reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic sel, input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_sel_map = sel; reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic cpu_evt(input logic p, input logic u, input logic [7:0] id);
        @(negedge clk);
        cpu_plug = p; cpu_unplug = u; cpu_id = id;
        @(negedge clk);
        cpu_plug = 1'b0; cpu_unplug = 1'b0;
    endtask

    task automatic slot_pulse();
        @(negedge clk);
        slot_evt = 1'b1;
        @(negedge clk);
        slot_evt = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(1'b1, 5'd0, d);  check("R1 map byte0", d, 8'h05);
        rd(1'b1, 5'd1, d);  check("R1 map byte1", d, 8'h00);
        for (int i = 0; i < 4; i++) begin
            rd(1'b0, 5'(i), d); check("R1 event byte", d, 8'h00);
        end
        check("R1 sci idle", sci, 1'b0);
    endtask

    task automatic t_cpu_hotplug();
        logic [7:0] d;
        cpu_evt(1'b1, 1'b0, 8'd9);
        rd(1'b1, 5'd1, d);  check("R6 plug id9", d, 8'h02);
        rd(1'b0, 5'd0, d);  check("R6 plug status", d, 8'h04);
        wr(1'b0, 5'd0, 8'h04);
        cpu_evt(1'b0, 1'b1, 8'd0);
        rd(1'b1, 5'd0, d);  check("R6 unplug id0", d, 8'h04);
        rd(1'b0, 5'd0, d);  check("R6 unplug status", d, 8'h04);
        cpu_evt(1'b1, 1'b0, 8'd255);
        rd(1'b1, 5'd31, d); check("R6 plug id255", d, 8'h80);
        wr(1'b0, 5'd0, 8'h04);
    endtask

    task automatic t_w1c();
        logic [7:0] d;
        slot_pulse();
        cpu_evt(1'b1, 1'b0, 8'd9);
        rd(1'b0, 5'd0, d);  check("R9 slot status", d, 8'h06);
        wr(1'b0, 5'd0, 8'h02);
        rd(1'b0, 5'd0, d);  check("R2 clear one bit", d, 8'h04);
        wr(1'b0, 5'd0, 8'h00);
        rd(1'b0, 5'd0, d);  check("R2 zero write keeps", d, 8'h04);
        wr(1'b0, 5'd0, 8'hFF);
        rd(1'b0, 5'd0, d);  check("R2 clear all", d, 8'h00);
        wr(1'b0, 5'd1, 8'hFF);
        rd(1'b0, 5'd1, d);  check("R2 high status stays 0", d, 8'h00);
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr(1'b0, 5'd2, 8'hA5);
        wr(1'b0, 5'd3, 8'h3C);
        rd(1'b0, 5'd2, d);  check("R3 enable lo", d, 8'hA5);
        rd(1'b0, 5'd3, d);  check("R3 enable hi", d, 8'h3C);
        wr(1'b0, 5'd2, 8'h00);
        rd(1'b0, 5'd2, d);  check("R3 enable lo cleared", d, 8'h00);
    endtask

    task automatic t_gpe_sci();
        wr(1'b0, 5'd2, 8'h04);
        cpu_evt(1'b1, 1'b0, 8'd3);
        #0.5; check("R5 cpu bit sci", sci, 1'b1);
        wr(1'b0, 5'd0, 8'h04);
        #0.5; check("R5 cleared sci", sci, 1'b0);
        wr(1'b0, 5'd2, 8'hF9);
        cpu_evt(1'b1, 1'b0, 8'd3);
        #0.5; check("R5 masked cpu bit", sci, 1'b0);
        wr(1'b0, 5'd3, 8'hFF);
        #0.5; check("R5 high byte no sci", sci, 1'b0);
        wr(1'b0, 5'd2, 8'h02);
        slot_pulse();
        #0.5; check("R5 slot bit sci", sci, 1'b1);
        wr(1'b0, 5'd0, 8'hFF);
        wr(1'b0, 5'd2, 8'h00);
        wr(1'b0, 5'd3, 8'h00);
    endtask

    task automatic t_pm1_sci();
        int hits [4] = '{0, 5, 8, 10};
        foreach (hits[i]) begin
            @(negedge clk);
            pm1_sts = 16'(1) << hits[i]; pm1_en = 16'(1) << hits[i];
            #0.5; check("R4 pm1 bit raises sci", sci, 1'b1);
        end
        @(negedge clk);
        pm1_sts = 16'hFADE; pm1_en = 16'hFADE;
        #0.5; check("R4 other bits ignored", sci, 1'b0);
        @(negedge clk);
        pm1_sts = 16'h0521; pm1_en = 16'h0000;
        #0.5; check("R4 pending not enabled", sci, 1'b0);
        @(negedge clk);
        pm1_sts = '0; pm1_en = '0;
    endtask

    task automatic t_tmr();
        @(negedge clk); pm1_en = 16'h0001; pm1_sts = 16'h0000;
        #0.5; check("R8 arm", tmr_arm, 1'b1);
        @(negedge clk); pm1_sts = 16'h0001;
        #0.5; check("R8 status blocks", tmr_arm, 1'b0);
        @(negedge clk); pm1_en = 16'hFFFE; pm1_sts = 16'h0000;
        #0.5; check("R8 disabled", tmr_arm, 1'b0);
        @(negedge clk); pm1_en = '0;
    endtask

    task automatic t_map_ro();
        logic [7:0] d;
        wr(1'b1, 5'd3, 8'hFF);
        rd(1'b1, 5'd3, d);  check("R7 map write ignored", d, 8'h00);
        wr(1'b1, 5'd2, 8'hFF);
        rd(1'b0, 5'd2, d);  check("R7 map write leaves enable", d, 8'h00);
        rd(1'b1, 5'd1, d);  check("R7 map byte1 intact", d, 8'h02);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk);
        reg_sel_map = 1'b0; reg_addr = 5'd0; reg_we = 1'b1; reg_wdata = 8'h06;
        cpu_plug = 1'b1; cpu_id = 8'd20; slot_evt = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; cpu_plug = 1'b0; slot_evt = 1'b0;
        rd(1'b0, 5'd0, d);  check("R10 event beats clear", d, 8'h06);
        wr(1'b0, 5'd0, 8'hFF);
        cpu_evt(1'b1, 1'b1, 8'd20);
        rd(1'b1, 5'd2, d);  check("R11 plug beats unplug", d, 8'h10);
        cpu_evt(1'b0, 1'b1, 8'd20);
        rd(1'b1, 5'd2, d);  check("R11 unplug alone", d, 8'h00);
        wr(1'b0, 5'd0, 8'hFF);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        wr(1'b0, 5'd2, 8'h5A);
        wr(1'b0, 5'd6, 8'hFF);
        rd(1'b0, 5'd6, d);  check("R12 unmapped reads zero", d, 8'h00);
        rd(1'b0, 5'd2, d);  check("R12 enable untouched", d, 8'h5A);
        slot_pulse();
        wr(1'b0, 5'd4, 8'hFF);
        rd(1'b0, 5'd0, d);  check("R12 status untouched", d, 8'h02);
    endtask

    initial begin
        rst = 1'b1; reg_sel_map = 1'b0; reg_addr = '0; reg_we = 1'b0;
        reg_wdata = '0; pm1_sts = '0; pm1_en = '0; slot_evt = 1'b0;
        cpu_plug = 1'b0; cpu_unplug = 1'b0; cpu_id = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_cpu_hotplug();
        t_w1c();
        t_enable();
        t_gpe_sci();
        t_pm1_sci();
        t_tmr();
        t_map_ro();
        t_collide();
        t_unmapped();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule